// File: doc/BRIEF.md
# Prioritised Interrupt Chain Controller

This block is the interrupt front end of a peripheral that sits in a daisy chain of devices. Each device in the chain gives way to the devices above it. Six internal request sources arrive as one-cycle set pulses. These are receive, transmit and line-status events for two channels. The block keeps a pending flag and an in-service flag for each source. It raises an active-low, open-drain interrupt request, which it models here as a drive-low enable. When the CPU runs an acknowledge cycle, the block decides whether this device wins the chain. If it wins, it returns an 8-bit vector while the read strobe is active.

Priority is resolved at two levels. Between devices, the chain-in and chain-out signals decide. Inside the device, a fixed order applies: source 0 is highest and source 5 is lowest. Winning an acknowledge moves the winning source from pending to in-service. The in-service state blocks all sources of equal or lower priority, and it also blocks the chain for every device below this one. A service-complete pulse retires the highest-priority in-service source. When vector modification is enabled, the winning source's index is written into three bits of a programmable base vector.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, no source is pending or in service, `irq_drive` is 0, `vec_oe` is 0 and `chain_out` equals `chain_in`.
- R2: A pulse on `src_req[i]` marks source i pending from the next clock edge. While `master_en` is 1 and nothing blocks it, `irq_drive` is 1 from that point.
- R3: While `master_en` is 0, `irq_drive` stays 0 and pending flags are kept. Setting `master_en` back to 1 raises `irq_drive` again with no new request.
- R4: `chain_out` is 0 whenever `chain_in` is 0. It equals `chain_in` when no source is in service and no acknowledge is in progress.
- R5: Once `intack` has been sampled high on a clock edge, `chain_out` is 0 while this device has an active request.
- R6: A win occurs on a clock edge where all of the following hold: sampled acknowledge, `chain_in` 1, an active request, `rd_n` 0, and no vector already held. From the next cycle, `vec_oe` is 1 with the vector. It stays held until `rd_n` returns high or the sampled acknowledge falls.
- R7: With `chain_in` 0, an acknowledge cycle returns no vector and changes no state; the request stays asserted afterwards.
- R8: Among eligible pending sources, the lowest index wins the acknowledge.
- R9: With `vec_mod_en` 1, the vector is the base vector with bits 3 to 1 replaced by the winner's index as a 3-bit binary number (source i gives code i). With `vec_mod_en` 0, the base vector is returned unchanged.
- R10: A win clears that source's pending flag and sets its in-service flag. While any source is in service, `chain_out` is 0, and sources of equal or lower priority cannot drive `irq_drive`.
- R11: A source of higher priority than every in-service source can still raise `irq_drive` and win, which nests service.
- R12: A `svc_done` pulse clears only the highest-priority in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 6 | One-cycle request pulses, bit 0 highest priority |
| master_en | input | 1 | Gates the interrupt request |
| vec_mod_en | input | 1 | Encode winning source into the vector |
| base_vec | input | 8 | Programmable base vector |
| svc_done | input | 1 | Retire the highest in-service source |
| chain_in | input | 1 | High when no upstream device is requesting or in service |
| chain_out | output | 1 | Enable passed to the next device downstream |
| intack | input | 1 | Acknowledge strobe, sampled on the rising clock edge |
| rd_n | input | 1 | Read strobe, active low |
| irq_drive | output | 1 | Pull-down enable for the open-drain request line |
| vec_out | output | 8 | Vector returned on a won acknowledge |
| vec_oe | output | 1 | Vector bus drive enable |

## Verification
The bench uses the default of six sources, which places both channels' receive, transmit and status inputs inside the 3-bit code field. Source indices 0, 1, 2, 4 and 5 all win at some point, so several distinct codes appear in bits 3 to 1. Two nested services let retirement be observed one level at a time. Simultaneous requests from both channels exercise the internal order. Runs with the chain input held low show that the block stays silent when an upstream device has the chain.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int MAX_SRC = 8;
  localparam int CODE_W  = $clog2(MAX_SRC);
  localparam int VEC_W   = 8;

  typedef logic [MAX_SRC-1:0] src_vec_t;

  // isolate the highest-priority (lowest index) set bit
  function automatic src_vec_t lowest_onehot(src_vec_t v);
    return v & (~v + 1'b1);
  endfunction

  // bits strictly above (in priority) the first set bit; all ones if none
  function automatic src_vec_t above_mask(src_vec_t v);
    if (v == '0) return '1;
    return lowest_onehot(v) - 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] onehot_code(src_vec_t oh);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < MAX_SRC; i++)
      if (oh[i]) c = CODE_W'(i);
    return c;
  endfunction

  function automatic logic [VEC_W-1:0] mod_vector(logic [VEC_W-1:0] base,
                                                  logic [CODE_W-1:0] code,
                                                  logic en);
    return en ? {base[VEC_W-1:4], code, base[0]} : base;
  endfunction
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_chain_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               win_evt,
  input  logic [NUM_SRC-1:0] win_oh,
  input  logic               svc_done,
  output logic [NUM_SRC-1:0] pending_q,
  output logic [NUM_SRC-1:0] ius_q
);
  logic [NUM_SRC-1:0] ius_top;
  assign ius_top = NUM_SRC'(lowest_onehot(MAX_SRC'(ius_q)));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic take;
    logic retire;
    assign take   = win_evt & win_oh[i];
    assign retire = svc_done & ius_top[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending_q[i] <= 1'b0;
        ius_q[i]     <= 1'b0;
      end else begin
        pending_q[i] <= (pending_q[i] & ~take) | src_req[i];
        ius_q[i]     <= (ius_q[i] & ~retire) | take;
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_chain_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] ius,
  input  logic               master_en,
  output logic [NUM_SRC-1:0] elig,
  output logic [NUM_SRC-1:0] win_oh,
  output logic [CODE_W-1:0]  win_code,
  output logic               req_active
);
  logic [NUM_SRC-1:0] mask;
  assign mask       = NUM_SRC'(above_mask(MAX_SRC'(ius)));
  assign elig       = pending & mask;
  assign win_oh     = NUM_SRC'(lowest_onehot(MAX_SRC'(elig)));
  assign win_code   = onehot_code(MAX_SRC'(win_oh));
  assign req_active = master_en & (|elig);
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux
  import irq_chain_pkg::*;
(
  input  logic [VEC_W-1:0]  base_vec,
  input  logic [CODE_W-1:0] code,
  input  logic              mod_en,
  output logic [VEC_W-1:0]  vec
);
  assign vec = mod_vector(base_vec, code, mod_en);
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               master_en,
  input  logic               vec_mod_en,
  input  logic [VEC_W-1:0]   base_vec,
  input  logic               svc_done,
  input  logic               chain_in,
  output logic               chain_out,
  input  logic               intack,
  input  logic               rd_n,
  output logic               irq_drive,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_oe
);
  logic [NUM_SRC-1:0] pending_q, ius_q, elig, win_oh;
  logic [CODE_W-1:0]  win_code;
  logic               req_active;
  logic               ack_q;
  logic               hold_q;
  logic [VEC_W-1:0]   vec_next, vec_q;
  logic               win_evt;

  irq_src_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .win_evt(win_evt), .win_oh(win_oh), .svc_done(svc_done),
    .pending_q(pending_q), .ius_q(ius_q)
  );

  irq_prio_resolve #(.NUM_SRC(NUM_SRC)) u_prio (
    .pending(pending_q), .ius(ius_q), .master_en(master_en),
    .elig(elig), .win_oh(win_oh), .win_code(win_code), .req_active(req_active)
  );

  irq_vec_mux u_vec (
    .base_vec(base_vec), .code(win_code), .mod_en(vec_mod_en), .vec(vec_next)
  );

  // named event for the checker: this device takes the acknowledge
  assign win_evt = ack_q & chain_in & req_active & ~rd_n & ~hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      hold_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      ack_q <= intack;
      if (win_evt) begin
        hold_q <= 1'b1;
        vec_q  <= vec_next;
      end else if (rd_n || !ack_q) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign irq_drive = req_active;
  assign chain_out = chain_in & ~(|ius_q) & ~(ack_q & req_active);
  assign vec_oe    = hold_q;
  assign vec_out   = hold_q ? vec_q : '0;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int NUM_SRC = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chain_in,
  input logic               chain_out,
  input logic               master_en,
  input logic               irq_drive,
  input logic               vec_oe,
  input logic               ack_q,
  input logic               win_evt,
  input logic               svc_done,
  input logic [NUM_SRC-1:0] ius_q
);
  AST_CHAIN_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |-> !chain_out); // R4
  AST_CHAIN_ACK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && irq_drive) |-> !chain_out); // R5
  AST_CHAIN_SERVICE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_q) |-> !chain_out); // R10
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq_drive); // R3
  AST_WIN_HOLDS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> (vec_oe && (|ius_q))); // R6
  AST_TOP_SERVICE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    ius_q[0] |-> !irq_drive); // R10
  AST_SVC_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && !win_evt && (|ius_q)) |=>
      ($countones(ius_q) + 1 == $countones($past(ius_q)))); // R12
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(chain_out),
  .master_en(master_en), .irq_drive(irq_drive), .vec_oe(vec_oe),
  .ack_q(ack_q), .win_evt(win_evt), .svc_done(svc_done), .ius_q(ius_q)
);

// File: tb/sim_irq_chain_ctrl.sv
`timescale 1ns/1ps
module sim_irq_chain_ctrl;
  localparam int NS = 6;
  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src_req = '0;
  logic master_en = 0, vec_mod_en = 0, svc_done = 0, chain_in = 1;
  logic intack = 0, rd_n = 1;
  logic [7:0] base_vec = 8'h50;
  logic chain_out, irq_drive, vec_oe;
  logic [7:0] vec_out;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_chain_ctrl #(.NUM_SRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .master_en(master_en),
    .vec_mod_en(vec_mod_en), .base_vec(base_vec), .svc_done(svc_done),
    .chain_in(chain_in), .chain_out(chain_out), .intack(intack), .rd_n(rd_n),
    .irq_drive(irq_drive), .vec_out(vec_out), .vec_oe(vec_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic mid();
    @(negedge clk);
  endtask

  task automatic pulse_req(logic [NS-1:0] m);
    src_req = m; tick(); src_req = '0;
  endtask

  task automatic retire();
    svc_done = 1; tick(); svc_done = 0;
  endtask

  // driver: queue expected vector, run an acknowledge cycle
  task automatic do_ack(logic [7:0] exp);
    exp_q.push_back(exp);
    intack = 1; tick(); mid();
    check("R5 chain_out in ack", {7'd0, chain_out}, 8'd0);
    rd_n = 0; tick(); mid();
    tick();
    rd_n = 1; intack = 0; tick(); mid();
    check("R6 vector released", {7'd0, vec_oe}, 8'd0);
  endtask

  // monitor: compare each newly presented vector with the queue head
  logic prev_oe = 0;
  always @(negedge clk) begin
    if (rst_n && vec_oe && !prev_oe) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6/R9 unexpected vector actual=%h expected=none", vec_out);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec_out !== e) begin
          bad++;
          $display("FAIL R8/R9 vector actual=%h expected=%h", vec_out, e);
        end
      end
    end
    prev_oe = vec_oe;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    mid();
    check("R1 irq_drive", {7'd0, irq_drive}, 8'd0);
    check("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
    check("R1 chain_out", {7'd0, chain_out}, 8'd1);

    pulse_req(6'b010000); mid();
    check("R3 gated", {7'd0, irq_drive}, 8'd0);
    master_en = 1; #1;
    check("R2/R3 re-enabled", {7'd0, irq_drive}, 8'd1);
    pulse_req(6'b000010); mid();
    check("R4 idle pass", {7'd0, chain_out}, 8'd1);

    // R7: chain_in low during acknowledge
    chain_in = 0; intack = 1; rd_n = 0; tick(); tick(); mid();
    check("R4 chain low", {7'd0, chain_out}, 8'd0);
    check("R7 no vector", {7'd0, vec_oe}, 8'd0);
    intack = 0; rd_n = 1; chain_in = 1; tick(); tick(); mid();
    check("R7 request kept", {7'd0, irq_drive}, 8'd1);

    // source 1 wins (source 4 lower), encoded code 1
    vec_mod_en = 1; base_vec = 8'h50;
    do_ack(8'h52);
    check("R10 chain blocked", {7'd0, chain_out}, 8'd0);
    check("R10 lower masked", {7'd0, irq_drive}, 8'd0);

    // R11: higher source nests, unmodified vector
    pulse_req(6'b000001); mid();
    check("R11 nested request", {7'd0, irq_drive}, 8'd1);
    vec_mod_en = 0; base_vec = 8'h5D;
    do_ack(8'h5D);
    check("R10 top in service", {7'd0, irq_drive}, 8'd0);

    // R12: retire one level at a time
    retire(); mid();
    check("R12 one retired", {7'd0, chain_out}, 8'd0);
    check("R12 src4 still masked", {7'd0, irq_drive}, 8'd0);
    retire(); mid();
    check("R12 all retired", {7'd0, chain_out}, 8'd1);
    check("R12 src4 visible", {7'd0, irq_drive}, 8'd1);
    vec_mod_en = 1; base_vec = 8'h50;
    do_ack(8'h58);
    retire(); mid();
    check("R10 pending cleared", {7'd0, irq_drive}, 8'd0);

    // R8: simultaneous requests, lower index first
    pulse_req(6'b100100);
    do_ack(8'h54);
    retire(); mid();
    check("R8 next visible", {7'd0, irq_drive}, 8'd1);
    do_ack(8'h5A);
    retire(); tick(); mid();
    check("R1 idle again", {7'd0, irq_drive}, 8'd0);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6 missing vectors actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule